// File: doc/BRIEF.md
# Gated Run Statistics Counter Bank

This block keeps 64-bit statistics for sixteen signals of a trigger system. Each signal feeds two kinds of counter. A time counter adds one on every clock while its level input is high. An edge counter adds one for each rising edge of its event input. Each counter exists in four gating contexts: ungated, qualified by the run flag, qualified by the spill flag, and qualified by both flags together. The result is 128 accumulators.

The level inputs are fourteen per-channel busy levels, a combined busy level, and a constant high that measures elapsed time. The event inputs are fourteen channel pulses, the trigger-candidate strobe and the accepted-trigger strobe. All inputs are assumed to be synchronous to `clk` already.

Software uses a 16-bit register port to read the counters and to set a small control register. That register clears all counters, freezes them, and holds an enable for error counting, which is driven out to a neighbouring block. A 64-bit counter takes four word addresses. When counting is live, the read path latches the whole counter on the access to word 0, so the four words of one read belong together.

Top module: `gated_stat_bank`

## Requirements
- R1: After reset, every counter is zero, the control register reads 0, `err_cnt_en` is 0 and `rdata` is 0.
- R2: A time counter adds one at each clock edge where its level is high, its context is open and the bank is not locked. Level index 15 is always high (elapsed time), index 14 is `xoff_any`, and indices 0–13 are `xoff_ch`.
- R3: An edge counter adds one at each clock edge where its event input is 1 and the registered copy of that input is 0, its context is open and the bank is unlocked. An input held high counts once. Event index 15 is `trig_acc`, index 14 is `trig_cand`, and indices 0–13 are `pulse_ch`.
- R4: Context codes: 0 = always open, 1 = open while `run_act`, 2 = open while `spill_act`, 3 = open while both are high.
- R5: For a counter read, `addr[9]` is 0, `addr[8]` picks the kind (0 = time, 1 = edge), `addr[7:6]` is the context, `addr[5:2]` is the signal index, and `addr[1:0]` is the 16-bit word, with word 0 least significant.
- R6: The control register is at address 0x200. Bit 1 is lock and bit 2 is the error-count enable, which drives `err_cnt_en`. Reads return these two bits in place and zeros elsewhere, including bit 0.
- R7: A write to 0x200 with bit 0 set zeroes all 128 counters at that clock edge, taking priority over any count in that cycle. The lock and enable bits of the same write still take effect.
- R8: While lock is 1, no counter changes except by clear. The edge-detect registers keep tracking their inputs, so an edge that happens during lock is not counted after unlock.
- R9: `rdata` is updated at the clock edge where `rd_en` is sampled high, and it keeps its value until the next read. An address that is neither the control register nor in the counter region reads 0.
- R10: While unlocked, a read of word 0 latches all 64 bits of the addressed counter. Reads of words 1–3 then return the latched bits, even if the counter has moved on since.
- R11: While locked, any word read returns that word of the live counter directly, with no latch needed first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xoff_ch | input | 14 | Per-channel busy levels (time counters 0–13) |
| xoff_any | input | 1 | Combined busy level (time counter 14) |
| pulse_ch | input | 14 | Per-channel pulse inputs (edge counters 0–13) |
| trig_cand | input | 1 | Trigger-candidate strobe (edge counter 14) |
| trig_acc | input | 1 | Accepted-trigger strobe (edge counter 15) |
| run_act | input | 1 | Run qualifier |
| spill_act | input | 1 | Spill qualifier |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 10 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered |
| err_cnt_en | output | 1 | Error-count enable from the control register |

## Verification
The assertions assume that clear and lock come only through a control write, that reset starts every counter and edge register at zero, and that the run and spill flags are plain synchronous levels, so a run-and-spill count can never pass its run-only twin. The bench changes inputs only at falling edges. It never starts a read and a control write in the same cycle, and it always reads word 0 of a counter before words 1–3 while unlocked. This keeps every read inside the latch rule that the requirements define.

// File: rtl/gstat_pkg.sv
package gstat_pkg;
  localparam int NCTX  = 4;
  localparam int NKIND = 2;

  typedef enum logic [1:0] {
    CTX_ALL   = 2'd0,
    CTX_RUN   = 2'd1,
    CTX_SPILL = 2'd2,
    CTX_BOTH  = 2'd3
  } ctx_e;

  // Whether a gating context lets counts through this cycle
  function automatic logic ctx_open(input logic [1:0] ctx, input logic run, input logic spill);
    case (ctx_e'(ctx))
      CTX_ALL:   return 1'b1;
      CTX_RUN:   return run;
      CTX_SPILL: return spill;
      default:   return run & spill;
    endcase
  endfunction

  // Flat counter index from kind, context and signal
  function automatic int cnt_index(input int kind, input int ctx, input int sig, input int nsig);
    return (kind * NCTX + ctx) * nsig + sig;
  endfunction
endpackage

// File: rtl/gstat_accum.sv
module gstat_accum #(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hold,
  input  logic          gate,
  input  logic          hit,
  output logic [CW-1:0] cnt
);
  logic bump;
  assign bump = gate & hit & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (bump) cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/gstat_ctrl.sv
module gstat_ctrl #(
  parameter int          AW        = 10,
  parameter int          DW        = 16,
  parameter logic [9:0]  CTRL_ADDR = 10'h200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [2:0]    wbits,
  output logic          clr_pulse,
  output logic          lock,
  output logic          err_en,
  output logic [DW-1:0] view
);
  logic hit_wr;
  assign hit_wr    = wr_en && (addr == AW'(CTRL_ADDR));
  assign clr_pulse = hit_wr & wbits[0];
  assign view      = DW'({err_en, lock, 1'b0});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock   <= 1'b0;
      err_en <= 1'b0;
    end else if (hit_wr) begin
      lock   <= wbits[1];
      err_en <= wbits[2];
    end
  end
endmodule

// File: rtl/gstat_rdpath.sv
module gstat_rdpath #(
  parameter int          NCNT      = 128,
  parameter int          CW        = 64,
  parameter int          DW        = 16,
  parameter int          AW        = 10,
  parameter logic [9:0]  CTRL_ADDR = 10'h200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic          lock,
  input  logic [DW-1:0] ctrl_view,
  input  logic [CW-1:0] cnt_i [NCNT],
  output logic [DW-1:0] rdata
);
  localparam int WSEL = $clog2(CW / DW);
  localparam int IDXW = $clog2(NCNT);
  localparam int TOPB = IDXW + WSEL;

  function automatic logic [DW-1:0] word_of(input logic [CW-1:0] v, input logic [WSEL-1:0] w);
    return v[int'(w) * DW +: DW];
  endfunction

  logic            is_ctrl, in_cnt;
  logic [IDXW-1:0] cidx;
  logic [WSEL-1:0] wsel;
  logic [CW-1:0]   sel, snap;

  assign is_ctrl = (addr == AW'(CTRL_ADDR));
  assign in_cnt  = ((addr >> TOPB) == '0);
  assign cidx    = addr[WSEL +: IDXW];
  assign wsel    = addr[WSEL-1:0];
  assign sel     = cnt_i[cidx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      snap  <= '0;
    end else if (rd_en) begin
      if (is_ctrl)           rdata <= ctrl_view;
      else if (!in_cnt)      rdata <= '0;
      else if (lock)         rdata <= word_of(sel, wsel);
      else if (wsel == '0) begin
        snap  <= sel;
        rdata <= sel[DW-1:0];
      end else               rdata <= word_of(snap, wsel);
    end
  end
endmodule

// File: rtl/gated_stat_bank.sv
module gated_stat_bank
  import gstat_pkg::*;
#(
  parameter int          NSIG      = 16,
  parameter int          CW        = 64,
  parameter int          DW        = 16,
  parameter int          AW        = 10,
  parameter logic [9:0]  CTRL_ADDR = 10'h200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSIG-3:0] xoff_ch,
  input  logic            xoff_any,
  input  logic [NSIG-3:0] pulse_ch,
  input  logic            trig_cand,
  input  logic            trig_acc,
  input  logic            run_act,
  input  logic            spill_act,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            err_cnt_en
);
  localparam int NCNT      = NKIND * NCTX * NSIG;
  localparam int ELAP_ALL  = (0 * NCTX + 0) * NSIG + NSIG - 1;
  localparam int ELAP_RUN  = (0 * NCTX + 1) * NSIG + NSIG - 1;
  localparam int ELAP_BOTH = (0 * NCTX + 3) * NSIG + NSIG - 1;
  localparam int EDGE0_ALL = (1 * NCTX + 0) * NSIG;

  // Named internal events, visible to the bound checker
  logic [NSIG-1:0] lvl_w, evt_w, evt_q, rise_w;
  logic [NCTX-1:0] gate_w;
  logic            clr_pulse, lock_q;
  logic [DW-1:0]   ctrl_view;
  logic [CW-1:0]   cnt [NCNT];
  logic [CW-1:0]   elap_all_w, elap_run_w, elap_both_w, edge0_all_w;

  assign lvl_w  = {1'b1, xoff_any, xoff_ch};
  assign evt_w  = {trig_acc, trig_cand, pulse_ch};
  assign rise_w = evt_w & ~evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_w;
  end

  gstat_ctrl #(.AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wbits     (wdata[2:0]),
    .clr_pulse (clr_pulse),
    .lock      (lock_q),
    .err_en    (err_cnt_en),
    .view      (ctrl_view)
  );

  for (genvar c = 0; c < NCTX; c++) begin : g_gate
    assign gate_w[c] = ctx_open(2'(c), run_act, spill_act);
  end

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
      for (genvar s = 0; s < NSIG; s++) begin : g_sig
        localparam int IDX = cnt_index(k, c, s, NSIG);
        logic hit;
        if (k == 0) begin : g_lvl
          assign hit = lvl_w[s];
        end else begin : g_edge
          assign hit = rise_w[s];
        end
        gstat_accum #(.CW(CW)) u_acc (
          .clk   (clk),
          .rst_n (rst_n),
          .clr   (clr_pulse),
          .hold  (lock_q),
          .gate  (gate_w[c]),
          .hit   (hit),
          .cnt   (cnt[IDX])
        );
      end
    end
  end

  assign elap_all_w  = cnt[ELAP_ALL];
  assign elap_run_w  = cnt[ELAP_RUN];
  assign elap_both_w = cnt[ELAP_BOTH];
  assign edge0_all_w = cnt[EDGE0_ALL];

  gstat_rdpath #(.NCNT(NCNT), .CW(CW), .DW(DW), .AW(AW), .CTRL_ADDR(CTRL_ADDR)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .addr      (addr),
    .lock      (lock_q),
    .ctrl_view (ctrl_view),
    .cnt_i     (cnt),
    .rdata     (rdata)
  );
endmodule

// File: rtl/gstat_chk.sv
module gstat_chk #(
  parameter int CW = 64,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lock,
  input logic          clr,
  input logic          rd_en,
  input logic [DW-1:0] rdata,
  input logic [CW-1:0] elap_all,
  input logic [CW-1:0] elap_run,
  input logic [CW-1:0] elap_both,
  input logic [CW-1:0] edge0_all,
  input logic          rise0
);
  // R2
  elapsed_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock && !clr) |=> (elap_all == $past(elap_all) + CW'(1)));

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !clr) |=> $stable(elap_all) && $stable(edge0_all));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (elap_all == '0) && (edge0_all == '0));

  // R4
  ctx_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    elap_both <= elap_run);

  // R3
  edge_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (edge0_all == $past(edge0_all)) || (edge0_all == $past(edge0_all) + CW'(1)));

  // R3
  edge_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise0 && !lock && !clr) |=> (edge0_all == $past(edge0_all) + CW'(1)));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind gated_stat_bank gstat_chk #(.CW(CW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lock      (lock_q),
  .clr       (clr_pulse),
  .rd_en     (rd_en),
  .rdata     (rdata),
  .elap_all  (elap_all_w),
  .elap_run  (elap_run_w),
  .elap_both (elap_both_w),
  .edge0_all (edge0_all_w),
  .rise0     (rise_w[0])
);

// File: tb/tb_gated_stat_bank.sv
module tb_gated_stat_bank;
  localparam logic [9:0] CTRL = 10'h200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] xoff_ch = '0, pulse_ch = '0;
  logic        xoff_any = 1'b0, trig_cand = 1'b0, trig_acc = 1'b0;
  logic        run_act = 1'b0, spill_act = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [9:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        err_cnt_en;

  int nvec = 0, nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gated_stat_bank dut (
    .clk(clk), .rst_n(rst_n), .xoff_ch(xoff_ch), .xoff_any(xoff_any),
    .pulse_ch(pulse_ch), .trig_cand(trig_cand), .trig_acc(trig_acc),
    .run_act(run_act), .spill_act(spill_act), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .err_cnt_en(err_cnt_en)
  );

  // Reference model built from the requirements
  logic [63:0] m [128];
  logic        mlock, merr;
  logic [15:0] pq;
  logic [63:0] tsnap;

  always @(posedge clk) begin : model
    bit clr, g, h;
    bit [15:0] lv, ev;
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) m[i] = '0;
      mlock = 0; merr = 0; pq = '0;
    end else begin
      lv  = {1'b1, xoff_any, xoff_ch};
      ev  = {trig_acc, trig_cand, pulse_ch};
      clr = wr_en && (addr == CTRL) && wdata[0];
      for (int k = 0; k < 2; k++)
        for (int c = 0; c < 4; c++)
          for (int s = 0; s < 16; s++) begin
            g = (c == 0) || (c == 1 && run_act) || (c == 2 && spill_act) || (c == 3 && run_act && spill_act);
            h = (k == 0) ? lv[s] : (ev[s] && !pq[s]);
            if (clr) m[(k*4+c)*16+s] = '0;
            else if (!mlock && g && h) m[(k*4+c)*16+s] = m[(k*4+c)*16+s] + 64'd1;
          end
      pq = ev;
      if (wr_en && addr == CTRL) begin
        mlock = wdata[1];
        merr  = wdata[2];
      end
    end
  end

  // Scoreboard
  logic [15:0] qexp [$];
  string       qtag [$];
  logic        rd_d = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_d <= rd_en;

  always @(negedge clk) begin
    if (rd_d && qexp.size() > 0) begin
      logic [15:0] e;
      string t;
      e = qexp.pop_front();
      t = qtag.pop_front();
      chk(rdata === e, t, rdata, e);
    end
  end

  task automatic rd(input logic [9:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1; addr = a;
    qexp.push_back(exp); qtag.push_back(tag);
    @(negedge clk);
    rd_en = 0;
  endtask

  // R5 address layout, R10/R11 expected word selection
  task automatic rd_cnt(input int k, input int c, input int s, input int w, input string tag);
    logic [15:0] e;
    int idx;
    idx = (k*4+c)*16+s;
    @(negedge clk);
    if (mlock) e = m[idx][w*16 +: 16];
    else if (w == 0) begin tsnap = m[idx]; e = tsnap[15:0]; end
    else e = tsnap[w*16 +: 16];
    rd_en = 1;
    addr = {1'b0, 1'(k), 2'(c), 4'(s), 2'(w)};
    qexp.push_back(e); qtag.push_back(tag);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic stir(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      run_act   = ($urandom % 3) != 0;
      spill_act = ($urandom % 2) != 0;
      xoff_ch   = 14'($urandom);
      xoff_any  = $urandom % 2;
      pulse_ch  = 14'($urandom);
      trig_cand = $urandom % 2;
      trig_acc  = ($urandom % 4) == 0;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(rdata === 16'h0, "R1 rdata", rdata, 16'h0);
    chk(err_cnt_en === 1'b0, "R1 err_cnt_en", {15'b0, err_cnt_en}, 16'h0);
    rd(CTRL, 16'h0000, "R1 ctrl");
    rd({1'b0, 1'b1, 2'd0, 4'd0, 2'd0}, 16'h0000, "R1 edge0");
    rd({1'b0, 1'b0, 2'd3, 4'd5, 2'd0}, 16'h0000, "R1 time5");
    rd(10'h3F0, 16'h0000, "R9 unmapped");

    // R2 R3 R4 R5 R10 over random traffic
    stir(400);
    for (int k = 0; k < 2; k++)
      for (int c = 0; c < 4; c++)
        for (int s = 0; s < 16; s++)
          for (int w = 0; w < 4; w++)
            rd_cnt(k, c, s, w, w == 0 ? (k == 0 ? "R2 R4 R5" : "R3 R4 R5") : "R10");

    // R3 held-high input counts once after a clear (R7)
    @(negedge clk); pulse_ch = '0; trig_cand = 0; trig_acc = 0;
    wr(CTRL, 16'h0001);
    @(negedge clk); pulse_ch = 14'h3FFF;
    repeat (20) @(negedge clk);
    rd({1'b0, 1'b1, 2'd0, 4'd0, 2'd0}, 16'h0001, "R3 held");
    rd_cnt(1, 0, 7, 0, "R3 held model");

    // R8 R11 lock, R6 control bits
    wr(CTRL, 16'h0006);
    chk(err_cnt_en === 1'b1, "R6 err_cnt_en", {15'b0, err_cnt_en}, 16'h1);
    rd(CTRL, 16'h0006, "R6 ctrl");
    stir(50);
    @(negedge clk); pulse_ch = '0;
    @(negedge clk); pulse_ch = 14'h0001;
    rd_cnt(0, 0, 15, 2, "R11 word2");
    rd_cnt(0, 0, 15, 0, "R8 R11");
    rd_cnt(0, 1, 15, 0, "R8 R11");
    rd_cnt(1, 0, 1, 1, "R11 word1");
    wr(CTRL, 16'h0000);
    repeat (5) @(negedge clk);
    rd_cnt(1, 0, 0, 0, "R8 edge in lock");

    // R7 clear while locked, bit 0 reads 0
    wr(CTRL, 16'h0003);
    rd({1'b0, 1'b0, 2'd0, 4'd15, 2'd0}, 16'h0000, "R7 locked clear");
    rd(CTRL, 16'h0002, "R6 R7 ctrl");
    chk(err_cnt_en === 1'b0, "R6 err off", {15'b0, err_cnt_en}, 16'h0);
    wr(CTRL, 16'h0000);

    // R10 carry into upper word
    stir(100);
    @(negedge clk); run_act = 1; spill_act = 0; xoff_ch = '0; xoff_any = 0;
    repeat (66000) @(negedge clk);
    for (int c = 0; c < 4; c++)
      for (int w = 0; w < 4; w++)
        rd_cnt(0, c, 15, w, "R10 R2 long");

    // R9 hold
    rd(CTRL, 16'h0000, "R9 read");
    repeat (2) @(negedge clk);
    rd_cnt(0, 0, 15, 0, "R9 read2");
    begin
      logic [15:0] keep;
      @(negedge clk);
      keep = rdata;
      repeat (6) @(negedge clk);
      chk(rdata === keep, "R9 hold", rdata, keep);
    end

    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule